// File: doc/BRIEF.md
# Clean-First LRU Eviction Controller for a Flash Page Buffer

This block makes the replacement decisions for a small, fully associative page buffer that sits in front of flash storage. It keeps, for every buffer slot, a page tag, a valid bit, a dirty bit and a recency rank. The recency order is split into two parts. The most recent slots form a working region. The last few slots, counted from the least recent end, form a clean-first window from which victims are drawn. The buffer holds the page data and performs the flash write-back elsewhere. This block only decides which slot is used and whether the page leaving it must be written back.

Each cycle with `acc_valid` high carries one access, either a read or a write, for one page tag. The result comes back combinationally in the same cycle: hit or miss, the matching slot, the slot the access lands in and, on a miss into a full buffer, the victim. All state updates at the following clock edge. Inside the window, a clean page is always chosen before a dirty one, because evicting a clean page costs no flash program. Among the clean pages in the window, the least recent one goes. Only when every page in the window is dirty does the least recent page of the whole buffer leave, and that eviction requests a write-back.

Top module: `cflru_evict_ctrl`

## Requirements
- R1: After reset no slot is valid, so the first access misses, `evict_valid` is 0 and the access lands in slot 0.
- R2: An access hits exactly when a valid slot holds its tag; `hit_slot` then names that slot and `acc_slot` equals it.
- R3: A miss while some slot is invalid lands in the lowest-numbered invalid slot and raises no eviction.
- R4: Every access, hit or miss, makes its slot the most recent one. All other slots that were more recent than it move down one place in the order.
- R5: `evict_valid` is high only for a miss while all slots are valid, and the new page then lands in the victim slot (`acc_slot` equals `evict_slot`).
- R6: When the window of the WINDOW least recent slots holds a clean page, the victim is the least recent clean page in that window.
- R7: When every page in the window is dirty, the victim is the least recent page of the buffer.
- R8: `evict_writeback` is 1 exactly when the victim page is dirty, and `evict_tag` gives the tag of the page leaving.
- R9: A write hit marks the page dirty. A read hit leaves the dirty state of the page unchanged.
- R10: Clean pages outside the window are never chosen, even when every page in the window is dirty.
- R11: A page brought in by a write miss is dirty. A page brought in by a read miss is clean.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_tag | input | TAG_W | Page tag of the access |
| acc_write | input | 1 | 1 for a write access, 0 for a read |
| hit | output | 1 | The access hits a valid slot |
| hit_slot | output | SLOT_W | Slot that matched (meaningful when hit) |
| acc_slot | output | SLOT_W | Slot that the access uses or fills |
| evict_valid | output | 1 | The miss forces an eviction |
| evict_slot | output | SLOT_W | Victim slot |
| evict_tag | output | TAG_W | Tag of the page being evicted |
| evict_writeback | output | 1 | The victim is dirty and must be written to flash |

## Verification
The bench checks the window where dirty pages sit at the tail and clean pages sit only in the working region. A design that looked past the window would wrongly evict a clean working page there. It also checks the case where a clean page sits above a dirty one inside the window. A design that took the plain LRU slot would then evict the dirty page and issue a needless write-back. Recency update is checked on read hits to dirty pages, because a design that skipped the move on reads would pick stale victims, and a design that cleared the dirty bit on a read hit would drop a write-back. Write misses are checked to install dirty pages, and the lowest-free-slot fill order is checked after reset. A long pseudo-random mix over a tag space twice the buffer size is compared access by access against a list-ordered model in the bench.

// File: rtl/cflru_pkg.sv
package cflru_pkg;

  // Rank a slot holds after an access to the slot currently at rank pivot.
  function automatic int next_rank(int cur, int pivot, bit is_target);
    if (is_target) return 0;
    if (cur < pivot) return cur + 1;
    return cur;
  endfunction

  // True when a rank lies in the tail window of size win out of n slots.
  function automatic bit in_tail(int rank, int n, int win);
    return rank >= (n - win);
  endfunction

endpackage

// File: rtl/cflru_lookup.sv
module cflru_lookup #(
  parameter int NUM_SLOTS = 4,
  parameter int TAG_W     = 8,
  localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [NUM_SLOTS-1:0]            valid_q,
  input  logic [NUM_SLOTS-1:0][TAG_W-1:0] tags_q,
  input  logic [TAG_W-1:0]                key,
  output logic                            match,
  output logic [SLOT_W-1:0]               match_slot,
  output logic                            free_any,
  output logic [SLOT_W-1:0]               free_slot
);

  logic [NUM_SLOTS-1:0] match_vec;

  generate
    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_cmp
      assign match_vec[i] = valid_q[i] && (tags_q[i] == key);
    end
  endgenerate

  always_comb begin
    match_slot = '0;
    free_slot  = '0;
    free_any   = 1'b0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      if (match_vec[i]) match_slot = SLOT_W'(i);
      if (!valid_q[i]) begin
        free_slot = SLOT_W'(i);
        free_any  = 1'b1;
      end
    end
  end

  assign match = |match_vec;

  // R2: a tag lives in at most one valid slot
  a_r2_single_match: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match_vec));

endmodule

// File: rtl/cflru_rank.sv
module cflru_rank #(
  parameter int NUM_SLOTS = 4,
  localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             upd_en,
  input  logic [SLOT_W-1:0]                upd_slot,
  output logic [NUM_SLOTS-1:0][SLOT_W-1:0] rank_q
);

  logic [NUM_SLOTS-1:0][SLOT_W-1:0] rank_d;
  logic [SLOT_W-1:0]                pivot;

  assign pivot = rank_q[upd_slot];

  always_comb begin
    rank_d = rank_q;
    if (upd_en) begin
      for (int i = 0; i < NUM_SLOTS; i++) begin
        rank_d[i] = SLOT_W'(cflru_pkg::next_rank(int'(rank_q[i]), int'(pivot),
                                                  SLOT_W'(i) == upd_slot));
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_SLOTS; i++) rank_q[i] <= SLOT_W'(i);
    end else begin
      rank_q <= rank_d;
    end
  end

  // R4: ranks always form a permutation, each value held by one slot
  generate
    for (genvar r = 0; r < NUM_SLOTS; r++) begin : g_perm
      logic [NUM_SLOTS-1:0] holders;
      for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_h
        assign holders[i] = (rank_q[i] == SLOT_W'(r));
      end
      a_r4_rank_perm: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(holders) == 1);
    end
  endgenerate

endmodule

// File: rtl/cflru_victim.sv
module cflru_victim #(
  parameter int NUM_SLOTS = 4,
  parameter int WINDOW    = 2,
  localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
  input  logic [NUM_SLOTS-1:0][SLOT_W-1:0] rank_q,
  input  logic [NUM_SLOTS-1:0]             dirty_q,
  output logic [SLOT_W-1:0]                vic_slot,
  output logic                             vic_dirty,
  output logic                             clean_found
);

  logic [SLOT_W-1:0] best_slot;
  logic [SLOT_W-1:0] lru_slot;
  int                best_rank;

  always_comb begin
    best_slot   = '0;
    lru_slot    = '0;
    best_rank   = -1;
    clean_found = 1'b0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (rank_q[i] == SLOT_W'(NUM_SLOTS - 1)) lru_slot = SLOT_W'(i);
      if (cflru_pkg::in_tail(int'(rank_q[i]), NUM_SLOTS, WINDOW) && !dirty_q[i]
          && int'(rank_q[i]) > best_rank) begin
        best_rank   = int'(rank_q[i]);
        best_slot   = SLOT_W'(i);
        clean_found = 1'b1;
      end
    end
    vic_slot  = clean_found ? best_slot : lru_slot;
    vic_dirty = dirty_q[vic_slot];
  end

endmodule

// File: rtl/cflru_evict_ctrl.sv
module cflru_evict_ctrl #(
  parameter int NUM_SLOTS = 4,
  parameter int TAG_W     = 8,
  parameter int WINDOW    = 2,
  localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic [TAG_W-1:0]  acc_tag,
  input  logic              acc_write,
  output logic              hit,
  output logic [SLOT_W-1:0] hit_slot,
  output logic [SLOT_W-1:0] acc_slot,
  output logic              evict_valid,
  output logic [SLOT_W-1:0] evict_slot,
  output logic [TAG_W-1:0]  evict_tag,
  output logic              evict_writeback
);

  logic [NUM_SLOTS-1:0]             valid_q;
  logic [NUM_SLOTS-1:0]             dirty_q;
  logic [NUM_SLOTS-1:0][TAG_W-1:0]  tags_q;
  logic [NUM_SLOTS-1:0][SLOT_W-1:0] rank_q;

  logic              look_hit;
  logic [SLOT_W-1:0] look_slot;
  logic              free_any;
  logic [SLOT_W-1:0] free_slot;
  logic [SLOT_W-1:0] vic_slot;
  logic              vic_dirty;
  logic              clean_found;
  logic [SLOT_W-1:0] tgt_slot;
  logic              buf_full;

  cflru_lookup #(.NUM_SLOTS(NUM_SLOTS), .TAG_W(TAG_W)) u_lookup (
    .clk        (clk),
    .rst_n      (rst_n),
    .valid_q    (valid_q),
    .tags_q     (tags_q),
    .key        (acc_tag),
    .match      (look_hit),
    .match_slot (look_slot),
    .free_any   (free_any),
    .free_slot  (free_slot)
  );

  cflru_rank #(.NUM_SLOTS(NUM_SLOTS)) u_rank (
    .clk      (clk),
    .rst_n    (rst_n),
    .upd_en   (acc_valid),
    .upd_slot (tgt_slot),
    .rank_q   (rank_q)
  );

  cflru_victim #(.NUM_SLOTS(NUM_SLOTS), .WINDOW(WINDOW)) u_victim (
    .rank_q      (rank_q),
    .dirty_q     (dirty_q),
    .vic_slot    (vic_slot),
    .vic_dirty   (vic_dirty),
    .clean_found (clean_found)
  );

  assign buf_full = &valid_q;
  assign tgt_slot = look_hit ? look_slot : (free_any ? free_slot : vic_slot);

  assign hit             = acc_valid && look_hit;
  assign hit_slot        = look_slot;
  assign acc_slot        = tgt_slot;
  assign evict_valid     = acc_valid && !look_hit && !free_any;
  assign evict_slot      = vic_slot;
  assign evict_tag       = tags_q[vic_slot];
  assign evict_writeback = evict_valid && vic_dirty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
      tags_q  <= '0;
    end else if (acc_valid) begin
      valid_q[tgt_slot] <= 1'b1;
      tags_q[tgt_slot]  <= acc_tag;
      dirty_q[tgt_slot] <= look_hit ? (dirty_q[tgt_slot] | acc_write) : acc_write;
    end
  end

  // Observation registers for the checks below
  logic              prev_acc;
  logic              prev_wr;
  logic [SLOT_W-1:0] prev_tgt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_acc <= 1'b0;
      prev_wr  <= 1'b0;
      prev_tgt <= '0;
    end else begin
      prev_acc <= acc_valid;
      prev_wr  <= acc_write;
      prev_tgt <= tgt_slot;
    end
  end

  a_r4_mru_after_access: assert property (@(posedge clk) disable iff (!rst_n)
    prev_acc |-> rank_q[prev_tgt] == '0);

  a_r9_write_sets_dirty: assert property (@(posedge clk) disable iff (!rst_n)
    (prev_acc && prev_wr) |-> dirty_q[prev_tgt]);

  a_r5_evict_only_full: assert property (@(posedge clk) disable iff (!rst_n)
    evict_valid |-> buf_full);

  a_r3_fill_invalid: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !look_hit && !buf_full) |-> !valid_q[acc_slot] && !evict_valid);

  a_r6_victim_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    evict_valid |-> int'(rank_q[evict_slot]) >= NUM_SLOTS - WINDOW);

  a_r7_dirty_victim_is_lru: assert property (@(posedge clk) disable iff (!rst_n)
    (evict_valid && !clean_found) |-> rank_q[evict_slot] == SLOT_W'(NUM_SLOTS - 1));

  a_r8_wb_matches_dirty: assert property (@(posedge clk) disable iff (!rst_n)
    evict_valid |-> (evict_writeback == dirty_q[evict_slot]));

endmodule

// File: tb/cflru_evict_ctrl_tb.sv
module cflru_evict_ctrl_tb;
  localparam int N  = 4;
  localparam int TW = 8;
  localparam int W  = 2;
  localparam int SW = $clog2(N);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          acc_valid = 1'b0;
  logic [TW-1:0] acc_tag = '0;
  logic          acc_write = 1'b0;
  logic          hit;
  logic [SW-1:0] hit_slot;
  logic [SW-1:0] acc_slot;
  logic          evict_valid;
  logic [SW-1:0] evict_slot;
  logic [TW-1:0] evict_tag;
  logic          evict_writeback;

  always #10 clk = ~clk;

  cflru_evict_ctrl #(.NUM_SLOTS(N), .TAG_W(TW), .WINDOW(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_tag(acc_tag),
    .acc_write(acc_write), .hit(hit), .hit_slot(hit_slot), .acc_slot(acc_slot),
    .evict_valid(evict_valid), .evict_slot(evict_slot), .evict_tag(evict_tag),
    .evict_writeback(evict_writeback)
  );

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // Model: order[0] is the most recent slot, order[N-1] the least recent.
  int m_order[N];
  bit m_valid[N];
  bit m_dirty[N];
  int m_tag[N];

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int k = 0; k < N; k++) begin
      m_order[k] = k; m_valid[k] = 0; m_dirty[k] = 0; m_tag[k] = 0;
    end
  endtask

  task automatic touch(int s);
    int pos;
    pos = 0;
    for (int k = 0; k < N; k++) if (m_order[k] == s) pos = k;
    for (int k = pos; k > 0; k--) m_order[k] = m_order[k-1];
    m_order[0] = s;
  endtask

  task automatic access(int tag, bit wr);
    int e_hit_slot, e_free, e_vic, e_slot;
    bit e_hit, e_ev;
    @(negedge clk);
    acc_valid = 1'b1; acc_tag = TW'(tag); acc_write = wr;
    e_hit = 0; e_hit_slot = 0; e_free = -1;
    for (int s = 0; s < N; s++)
      if (m_valid[s] && m_tag[s] == tag) begin e_hit = 1; e_hit_slot = s; end
    for (int s = N - 1; s >= 0; s--) if (!m_valid[s]) e_free = s;
    e_vic = m_order[N-1];
    for (int k = N - W; k < N; k++) if (!m_dirty[m_order[k]]) e_vic = m_order[k];
    e_ev = !e_hit && (e_free < 0);
    e_slot = e_hit ? e_hit_slot : (e_free >= 0 ? e_free : e_vic);
    #5;
    chk(hit == e_hit, "R2 hit", int'(hit), int'(e_hit));
    if (e_hit) chk(hit_slot == SW'(e_hit_slot), "R2 hit_slot", int'(hit_slot), e_hit_slot);
    chk(evict_valid == e_ev, "R5 evict_valid", int'(evict_valid), int'(e_ev));
    if (!e_hit && !e_ev)
      chk(acc_slot == SW'(e_slot), "R3 fill slot", int'(acc_slot), e_slot);
    if (e_ev) begin
      chk(evict_slot == SW'(e_vic), "R6/R7/R10/R4 victim", int'(evict_slot), e_vic);
      chk(acc_slot == evict_slot, "R5 fill into victim", int'(acc_slot), int'(evict_slot));
      chk(evict_writeback == m_dirty[e_vic], "R8/R9/R11 writeback",
          int'(evict_writeback), int'(m_dirty[e_vic]));
      chk(evict_tag == TW'(m_tag[e_vic]), "R8 evict_tag", int'(evict_tag), m_tag[e_vic]);
    end
    // model update
    m_valid[e_slot] = 1;
    m_tag[e_slot]   = tag;
    m_dirty[e_slot] = e_hit ? (m_dirty[e_slot] | wr) : wr;
    touch(e_slot);
    @(posedge clk);
    #1;
    acc_valid = 1'b0;
  endtask

  initial begin
    #4000000;
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    bit [15:0] lfsr;
    model_reset();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk); #5;
    // R1: idle after reset
    chk(hit == 1'b0, "R1 hit after reset", int'(hit), 0);
    chk(evict_valid == 1'b0, "R1 evict after reset", int'(evict_valid), 0);
    // R1/R3: fill order from slot 0
    access(1, 0); access(2, 0); access(3, 0); access(4, 0);
    // R9: write hits make 1 and 2 dirty; R4: read hits move 4 and 3 to MRU
    access(1, 1); access(2, 1); access(4, 0); access(3, 0);
    // R10/R7: window holds dirty 2 and 1, clean 3,4 outside: victim tag 1 with write-back
    access(5, 0);
    // R6: clean 5 is most recent; make window {clean 4 above dirty 2}
    access(3, 0); access(5, 0);
    access(6, 0);
    // R11: write miss installs dirty, R9: read hit keeps it dirty
    access(7, 1); access(7, 0);
    access(8, 0); access(9, 0); access(10, 0); access(11, 0);
    // pseudo-random mix
    lfsr = 16'hACE1;
    for (int n = 0; n < 4000; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      access(int'(lfsr[2:0]), lfsr[7] & lfsr[5]);
    end
    // reset again and re-check R1
    rst_n = 1'b0; model_reset();
    @(posedge clk); #1 rst_n = 1'b1;
    access(9, 1);
    chk(acc_slot == '0, "R1 first fill slot 0", int'(acc_slot), 0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule